// File: doc/BRIEF.md
# Lifecycle State Controller

This block guards the lifecycle of a chip. A persistent lifecycle code lives in nonvolatile storage outside the block; the block decodes it into one of four ordered phases (chip manufacture, device manufacture, secured, returned), or into an invalid phase. It also decodes a one-time test-mode word from the same storage. Writes to the nonvolatile cells go out through a single write port, and the storage reflects a write on the following clock edge.

Software reaches the block through a plain 32-bit register bus. The bus reads status and arms a few privileged controls. Each control responds only to one exact high-weight constant, so a stray or glitched write cannot trip it. A separate request port asks for a phase change. The controller checks every precondition and answers with a status code one cycle later. When the change is legal, it programs the new phase code into storage. Phases move forward one step at a time and never return to chip manufacture. A sticky fatal flag freezes the controller until reset.

Top module: `lifecycle_ctrl`

## Requirements
- R1: After reset the fatal flag is clear, provisioning is inactive, `resp_valid_o` and `nv_wr_en_o` are low, and the register reads reflect the stored phase and mode.
- R2: Reads are combinational from `reg_addr_i`. Byte offset 0x000 gives the phase index. Offset 0x004 gives `key_err_i` in bit 0. Offset 0x008 gives the mode index. Offset 0x00C gives the fatal flag in bit 0. Offset 0x014 gives provisioning-active in bit 0. Offset 0x01C gives the parameter `OTP_BYTES`. Offset 0x020 gives `gp_cfg_i`. Every other offset reads 0.
- R3: Stored phase codes are 8-bit: 0x1E for chip manufacture (index 0), 0x2D for device manufacture (1), 0x4B for secured (2) and 0x87 for returned (3). Any other code reads as index 7. While the fatal flag is set, the phase read returns 6.
- R4: Writing exactly 0xFA7A1EEE to offset 0x00C sets the fatal flag. Any other value written there leaves the flag clear.
- R5: The fatal flag clears only on reset. While it is set, every register write is ignored and every request answers status 1 (fatal).
- R6: Writing exactly 0x5EC10E1E to offset 0x014 starts provisioning. The enable reads 1 once `SP_DELAY` cycles have passed and stays 1 until reset. Other values have no effect.
- R7: The stored mode word decodes as follows: 0 is virgin (index 0), 0x0000FFFF is mode A (1), 0xFFFF0000 is mode B (2), and anything else is index 3. A write to offset 0x008 programs the mode only when the phase is chip manufacture, the mode is virgin and the value is 0x0000FFFF or 0xFFFF0000. Any other write to that offset leaves the mode unchanged.
- R8: A request on `req_valid_i`, with a target phase index on `req_state_i`, is answered on the next cycle by a one-cycle `resp_valid_o` pulse carrying `resp_status_o`. The status codes are 0 ok, 1 fatal, 2 invalid phase, 3 illegal step, 4 no test mode, 5 not provisioning, 6 busy.
- R9: The only steps that succeed are index 0 to 1, 1 to 2 and 2 to 3. A successful step writes the new 8-bit code to storage with `nv_wr_sel_o` low. A request for chip manufacture, or for a non-adjacent phase, answers 3.
- R10: Preconditions are checked in this order: fatal (1), busy (6), an invalid current phase or a target index above 3 (2), target equal to the current phase (0, with no storage write), mode not A or B (4), provisioning inactive (5), then the step rule (3).
- R11: A request that arrives in the cycle just after any storage write answers 6 (busy) and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| req_valid_i | input | 1 | Phase change request |
| req_state_i | input | 3 | Requested phase index |
| resp_valid_o | output | 1 | Response strobe |
| resp_status_o | output | 3 | Response status code |
| key_err_i | input | 1 | Key check error flag, read back only |
| gp_cfg_i | input | 32 | General configuration word, read back only |
| nv_state_i | input | 8 | Stored phase code |
| nv_mode_i | input | 32 | Stored test-mode word |
| nv_wr_en_o | output | 1 | Storage write strobe |
| nv_wr_sel_o | output | 1 | Storage field select: 0 phase, 1 mode |
| nv_wr_data_o | output | 32 | Storage write value |

## Verification
The bench builds the controller with `SP_DELAY` set to 3 and `OTP_BYTES` set to 2048. The short delay lets one run observe provisioning both before and after it becomes active, and the size value differs from the default, which confirms that the read path tracks the parameter. The bench models storage as two registers that it can also overwrite directly. It uses this to inject single-bit-flipped phase codes and corrupt mode words, to place the controller in a late phase with a virgin mode, and to walk the whole forward chain including the busy window after each write.

// File: rtl/lcs_pkg.sv
package lcs_pkg;

    typedef enum logic [2:0] {
        LC_CM    = 3'd0,
        LC_DM    = 3'd1,
        LC_SE    = 3'd2,
        LC_RMA   = 3'd3,
        LC_FATAL = 3'd6,
        LC_BAD   = 3'd7
    } lc_state_e;

    typedef enum logic [1:0] {
        TM_VIRGIN = 2'd0,
        TM_A      = 2'd1,
        TM_B      = 2'd2,
        TM_BAD    = 2'd3
    } tm_e;

    typedef enum logic [2:0] {
        RS_OK        = 3'd0,
        RS_FATAL     = 3'd1,
        RS_BAD_STATE = 3'd2,
        RS_BAD_STEP  = 3'd3,
        RS_NO_MODE   = 3'd4,
        RS_NO_PROV   = 3'd5,
        RS_BUSY      = 3'd6
    } rs_e;

    localparam int CODE_W = 8;
    localparam int WORD_W = 32;

    localparam logic [CODE_W-1:0] CODE_CM  = 8'h1E;
    localparam logic [CODE_W-1:0] CODE_DM  = 8'h2D;
    localparam logic [CODE_W-1:0] CODE_SE  = 8'h4B;
    localparam logic [CODE_W-1:0] CODE_RMA = 8'h87;

    localparam logic [WORD_W-1:0] MAGIC_FATAL = 32'hFA7A1EEE;
    localparam logic [WORD_W-1:0] MAGIC_PROV  = 32'h5EC10E1E;
    localparam logic [WORD_W-1:0] MODE_A_WORD = 32'h0000FFFF;
    localparam logic [WORD_W-1:0] MODE_B_WORD = 32'hFFFF0000;

    localparam int OFS_STATE = 'h000;
    localparam int OFS_KEY   = 'h004;
    localparam int OFS_MODE  = 'h008;
    localparam int OFS_FATAL = 'h00C;
    localparam int OFS_PROV  = 'h014;
    localparam int OFS_SIZE  = 'h01C;
    localparam int OFS_GPC   = 'h020;

    typedef struct packed {
        logic               fatal;
        logic               resp_valid;
        rs_e                resp_status;
        logic               nv_wr;
        logic               nv_sel;
        logic [WORD_W-1:0]  nv_data;
    } ctl_t;

    function automatic logic [CODE_W-1:0] code_of(lc_state_e s);
        case (s)
            LC_DM:   code_of = CODE_DM;
            LC_SE:   code_of = CODE_SE;
            LC_RMA:  code_of = CODE_RMA;
            default: code_of = CODE_CM;
        endcase
    endfunction

endpackage

// File: rtl/lcs_decode.sv
module lcs_decode
    import lcs_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    input  logic [WORD_W-1:0] mode_word_i,
    output lc_state_e         state_o,
    output tm_e               mode_o
);

    always_comb begin
        case (code_i)
            CODE_CM:  state_o = LC_CM;
            CODE_DM:  state_o = LC_DM;
            CODE_SE:  state_o = LC_SE;
            CODE_RMA: state_o = LC_RMA;
            default:  state_o = LC_BAD;
        endcase
    end

    always_comb begin
        case (mode_word_i)
            '0:          mode_o = TM_VIRGIN;
            MODE_A_WORD: mode_o = TM_A;
            MODE_B_WORD: mode_o = TM_B;
            default:     mode_o = TM_BAD;
        endcase
    end

endmodule

// File: rtl/lcs_prov_timer.sv
module lcs_prov_timer #(
    parameter int SP_DELAY = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic active_o
);

    localparam int CNT_W = $clog2(SP_DELAY + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SP_DELAY - 1);

    typedef struct packed {
        logic             run;
        logic             act;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.run) begin
            if (tmr_q.cnt == LAST) begin
                tmr_d.run = 1'b0;
                tmr_d.act = 1'b1;
                tmr_d.cnt = '0;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end else if (start_i && !tmr_q.act) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign active_o = tmr_q.act;

endmodule

// File: rtl/lifecycle_ctrl.sv
module lifecycle_ctrl
    import lcs_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int OTP_BYTES = 4096,
    parameter int SP_DELAY  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    input  logic              req_valid_i,
    input  logic [2:0]        req_state_i,
    output logic              resp_valid_o,
    output logic [2:0]        resp_status_o,
    input  logic              key_err_i,
    input  logic [31:0]       gp_cfg_i,
    input  logic [7:0]        nv_state_i,
    input  logic [31:0]       nv_mode_i,
    output logic              nv_wr_en_o,
    output logic              nv_wr_sel_o,
    output logic [31:0]       nv_wr_data_o
);

    localparam logic [ADDR_W-1:0] A_STATE = ADDR_W'(OFS_STATE);
    localparam logic [ADDR_W-1:0] A_KEY   = ADDR_W'(OFS_KEY);
    localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(OFS_MODE);
    localparam logic [ADDR_W-1:0] A_FATAL = ADDR_W'(OFS_FATAL);
    localparam logic [ADDR_W-1:0] A_PROV  = ADDR_W'(OFS_PROV);
    localparam logic [ADDR_W-1:0] A_SIZE  = ADDR_W'(OFS_SIZE);
    localparam logic [ADDR_W-1:0] A_GPC   = ADDR_W'(OFS_GPC);

    ctl_t      ctl_d, ctl_q;
    lc_state_e cur_state;
    tm_e       cur_mode;
    lc_state_e tgt_state;
    logic      tgt_ok;
    logic      step_ok;
    logic      prov_active;
    logic      prov_start;
    logic      wr_ok;
    logic      mode_wr_ok;
    logic      fatal_w;
    logic      prov_active_w;

    lcs_decode u_dec (
        .code_i      (nv_state_i),
        .mode_word_i (nv_mode_i),
        .state_o     (cur_state),
        .mode_o      (cur_mode)
    );

    lcs_prov_timer #(.SP_DELAY(SP_DELAY)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (prov_start),
        .active_o (prov_active)
    );

    // Writes are honoured only while no fatal condition is latched.
    assign wr_ok      = reg_wr_i && !ctl_q.fatal;
    assign prov_start = wr_ok && (reg_addr_i == A_PROV) && (reg_wdata_i == MAGIC_PROV);
    assign mode_wr_ok = wr_ok && (reg_addr_i == A_MODE) && !ctl_q.nv_wr &&
                        (cur_state == LC_CM) && (cur_mode == TM_VIRGIN) &&
                        ((reg_wdata_i == MODE_A_WORD) || (reg_wdata_i == MODE_B_WORD));

    assign tgt_ok    = (req_state_i <= 3'd3);
    assign tgt_state = lc_state_e'(req_state_i);

    // Only single forward steps are legal.
    always_comb begin
        case (cur_state)
            LC_CM:   step_ok = (tgt_state == LC_DM);
            LC_DM:   step_ok = (tgt_state == LC_SE);
            LC_SE:   step_ok = (tgt_state == LC_RMA);
            default: step_ok = 1'b0;
        endcase
    end

    always_comb begin
        ctl_d             = ctl_q;
        ctl_d.resp_valid  = 1'b0;
        ctl_d.resp_status = RS_OK;
        ctl_d.nv_wr       = 1'b0;
        ctl_d.nv_sel      = 1'b0;
        ctl_d.nv_data     = '0;

        if (wr_ok && (reg_addr_i == A_FATAL) && (reg_wdata_i == MAGIC_FATAL)) begin
            ctl_d.fatal = 1'b1;
        end

        if (req_valid_i) begin
            ctl_d.resp_valid = 1'b1;
            if (ctl_q.fatal) begin
                ctl_d.resp_status = RS_FATAL;
            end else if (ctl_q.nv_wr) begin
                ctl_d.resp_status = RS_BUSY;
            end else if ((cur_state == LC_BAD) || !tgt_ok) begin
                ctl_d.resp_status = RS_BAD_STATE;
            end else if (tgt_state == cur_state) begin
                ctl_d.resp_status = RS_OK;
            end else if (!((cur_mode == TM_A) || (cur_mode == TM_B))) begin
                ctl_d.resp_status = RS_NO_MODE;
            end else if (!prov_active) begin
                ctl_d.resp_status = RS_NO_PROV;
            end else if (!step_ok) begin
                ctl_d.resp_status = RS_BAD_STEP;
            end else begin
                ctl_d.resp_status = RS_OK;
                ctl_d.nv_wr       = 1'b1;
                ctl_d.nv_sel      = 1'b0;
                ctl_d.nv_data     = {{(WORD_W-CODE_W){1'b0}}, code_of(tgt_state)};
            end
        end else if (mode_wr_ok) begin
            ctl_d.nv_wr   = 1'b1;
            ctl_d.nv_sel  = 1'b1;
            ctl_d.nv_data = reg_wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        case (reg_addr_i)
            A_STATE: reg_rdata_o = ctl_q.fatal ? {29'd0, LC_FATAL} : {29'd0, cur_state};
            A_KEY:   reg_rdata_o = {31'd0, key_err_i};
            A_MODE:  reg_rdata_o = {30'd0, cur_mode};
            A_FATAL: reg_rdata_o = {31'd0, ctl_q.fatal};
            A_PROV:  reg_rdata_o = {31'd0, prov_active};
            A_SIZE:  reg_rdata_o = 32'(OTP_BYTES);
            A_GPC:   reg_rdata_o = gp_cfg_i;
            default: reg_rdata_o = '0;
        endcase
    end

    assign resp_valid_o  = ctl_q.resp_valid;
    assign resp_status_o = ctl_q.resp_status;
    assign nv_wr_en_o    = ctl_q.nv_wr;
    assign nv_wr_sel_o   = ctl_q.nv_sel;
    assign nv_wr_data_o  = ctl_q.nv_data;
    assign fatal_w       = ctl_q.fatal;
    assign prov_active_w = prov_active;

endmodule

// File: rtl/lifecycle_ctrl_chk.sv
module lifecycle_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        resp_valid,
    input logic        nv_wr_en,
    input logic        nv_wr_sel,
    input logic [31:0] nv_wr_data,
    input logic        fatal,
    input logic        prov_active
);

    a_r5_fatal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fatal |=> fatal);

    a_r5_fatal_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (fatal && $past(fatal)) |-> !nv_wr_en);

    a_r6_prov_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        prov_active |=> prov_active);

    a_r8_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);

    a_r8_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);

    a_r9_forward_code: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_wr_en && !nv_wr_sel) |->
            ((nv_wr_data == 32'h2D) || (nv_wr_data == 32'h4B) || (nv_wr_data == 32'h87)));

    a_r7_mode_word: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_wr_en && nv_wr_sel) |->
            ((nv_wr_data == 32'h0000FFFF) || (nv_wr_data == 32'hFFFF0000)));

    a_r11_write_gap: assert property (@(posedge clk) disable iff (!rst_n)
        nv_wr_en |=> !nv_wr_en);

endmodule

bind lifecycle_ctrl lifecycle_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid_i),
    .resp_valid  (resp_valid_o),
    .nv_wr_en    (nv_wr_en_o),
    .nv_wr_sel   (nv_wr_sel_o),
    .nv_wr_data  (nv_wr_data_o),
    .fatal       (fatal_w),
    .prov_active (prov_active_w)
);

// File: tb/sim_lifecycle_ctrl.sv
`timescale 1ns/1ps
module sim_lifecycle_ctrl;

    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              req_valid = 1'b0;
    logic [2:0]        req_state = '0;
    logic              resp_valid;
    logic [2:0]        resp_status;
    logic              key_err = 1'b1;
    logic [31:0]       gp_cfg = 32'hC0DE_1234;
    logic [7:0]        nv_state = 8'h1E;
    logic [31:0]       nv_mode = '0;
    logic              nv_wr_en;
    logic              nv_wr_sel;
    logic [31:0]       nv_wr_data;

    logic              poke_en = 1'b0;
    logic [7:0]        poke_state = 8'h1E;
    logic [31:0]       poke_mode = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lifecycle_ctrl #(.ADDR_W(ADDR_W), .OTP_BYTES(2048), .SP_DELAY(3)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr_i      (reg_wr),
        .reg_addr_i    (reg_addr),
        .reg_wdata_i   (reg_wdata),
        .reg_rdata_o   (reg_rdata),
        .req_valid_i   (req_valid),
        .req_state_i   (req_state),
        .resp_valid_o  (resp_valid),
        .resp_status_o (resp_status),
        .key_err_i     (key_err),
        .gp_cfg_i      (gp_cfg),
        .nv_state_i    (nv_state),
        .nv_mode_i     (nv_mode),
        .nv_wr_en_o    (nv_wr_en),
        .nv_wr_sel_o   (nv_wr_sel),
        .nv_wr_data_o  (nv_wr_data)
    );

    // Storage model: bench pokes win over design writes.
    always @(posedge clk) begin
        if (poke_en) begin
            nv_state <= poke_state;
            nv_mode  <= poke_mode;
        end else if (nv_wr_en) begin
            if (nv_wr_sel) nv_mode <= nv_wr_data;
            else           nv_state <= nv_wr_data[7:0];
        end
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic poke(input logic [7:0] st, input logic [31:0] md);
        @(negedge clk);
        poke_state = st;
        poke_mode  = md;
        poke_en    = 1'b1;
        @(negedge clk);
        poke_en    = 1'b0;
    endtask

    task automatic wr(input int ofs, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = ADDR_W'(ofs);
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input int ofs, output logic [31:0] d);
        reg_addr = ADDR_W'(ofs);
        #2;
        d = reg_rdata;
    endtask

    task automatic request(input logic [2:0] tgt, output logic v, output logic [2:0] st);
        @(negedge clk);
        req_state = tgt;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        v  = resp_valid;
        st = resp_status;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 resp idle", {31'd0, resp_valid}, 0);
        chk("R1 nv write idle", {31'd0, nv_wr_en}, 0);
        rd('h000, d); chk("R2 R3 phase CM", d, 0);
        rd('h004, d); chk("R2 key err", d, 1);
        rd('h008, d); chk("R2 mode virgin", d, 0);
        rd('h00C, d); chk("R1 fatal clear", d, 0);
        rd('h014, d); chk("R1 prov inactive", d, 0);
        rd('h01C, d); chk("R2 otp size", d, 2048);
        rd('h020, d); chk("R2 gp cfg", d, 32'hC0DE_1234);
        rd('h010, d); chk("R2 unmapped", d, 0);
    endtask

    task automatic t_mode();
        logic v; logic [2:0] s; logic [31:0] d;
        request(3'd1, v, s);
        chk("R8 resp valid", {31'd0, v}, 1);
        chk("R10 no mode", {29'd0, s}, 4);
        wr('h008, 32'h1234_5678);
        rd('h008, d); chk("R7 bad value ignored", d, 0);
        wr('h008, 32'hFFFF_0000);
        rd('h008, d); chk("R7 mode B", d, 2);
        wr('h008, 32'h0000_FFFF);
        rd('h008, d); chk("R7 one-time", d, 2);
    endtask

    task automatic t_prov();
        logic v; logic [2:0] s; logic [31:0] d;
        request(3'd1, v, s);
        chk("R10 not provisioning", {29'd0, s}, 5);
        wr('h014, 32'h5EC1_0E1F);
        rd('h014, d); chk("R6 wrong magic", d, 0);
        @(negedge clk);
        reg_addr = ADDR_W'('h014); reg_wdata = 32'h5EC1_0E1E; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        rd('h014, d); chk("R6 not yet active", d, 0);
        repeat (4) @(negedge clk);
        rd('h014, d); chk("R6 active", d, 1);
    endtask

    task automatic t_same_and_illegal();
        logic v; logic [2:0] s; logic [31:0] d;
        request(3'd0, v, s);
        chk("R10 same phase ok", {29'd0, s}, 0);
        rd('h000, d); chk("R10 same phase unchanged", d, 0);
        request(3'd2, v, s); chk("R9 skip step", {29'd0, s}, 3);
        request(3'd3, v, s); chk("R9 skip two", {29'd0, s}, 3);
        request(3'd5, v, s); chk("R10 bad target", {29'd0, s}, 2);
    endtask

    task automatic t_busy();
        logic [2:0] s1; logic [2:0] s2; logic [31:0] d;
        @(negedge clk);
        req_state = 3'd1; req_valid = 1'b1;
        @(negedge clk);
        req_state = 3'd2;
        s1 = resp_status;
        @(negedge clk);
        req_valid = 1'b0;
        s2 = resp_status;
        @(negedge clk);
        chk("R9 CM to DM", {29'd0, s1}, 0);
        chk("R11 busy", {29'd0, s2}, 6);
        rd('h000, d); chk("R11 busy no write", d, 1);
    endtask

    task automatic t_walk();
        logic v; logic [2:0] s; logic [31:0] d;
        request(3'd2, v, s); chk("R9 DM to SE", {29'd0, s}, 0);
        rd('h000, d); chk("R9 phase SE", d, 2);
        request(3'd0, v, s); chk("R9 back to CM", {29'd0, s}, 3);
        request(3'd1, v, s); chk("R9 backward", {29'd0, s}, 3);
        request(3'd3, v, s); chk("R9 SE to RMA", {29'd0, s}, 0);
        rd('h000, d); chk("R3 phase RMA", d, 3);
        request(3'd0, v, s); chk("R9 RMA to CM", {29'd0, s}, 3);
    endtask

    task automatic t_late_mode_and_corrupt();
        logic v; logic [2:0] s; logic [31:0] d;
        poke(8'h2D, 32'h0);
        wr('h008, 32'h0000_FFFF);
        rd('h008, d); chk("R7 mode outside CM ignored", d, 0);
        poke(8'h1F, 32'h0000_FFFE);
        rd('h000, d); chk("R3 flipped code", d, 7);
        rd('h008, d); chk("R7 corrupt mode", d, 3);
        request(3'd1, v, s); chk("R10 invalid current", {29'd0, s}, 2);
    endtask

    task automatic t_fatal();
        logic v; logic [2:0] s; logic [31:0] d;
        poke(8'h4B, 32'h0000_FFFF);
        wr('h00C, 32'hFA7A_1EEF);
        rd('h00C, d); chk("R4 wrong magic", d, 0);
        wr('h00C, 32'hFA7A_1EEE);
        rd('h00C, d); chk("R4 fatal set", d, 1);
        rd('h000, d); chk("R3 fatal phase read", d, 6);
        request(3'd3, v, s); chk("R5 fatal request", {29'd0, s}, 1);
        poke(8'h1E, 32'h0);
        wr('h008, 32'h0000_FFFF);
        rd('h008, d); chk("R5 write blocked", d, 0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd('h00C, d); chk("R5 reset clears fatal", d, 0);
        rd('h014, d); chk("R1 reset clears prov", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mode();
        t_prov();
        t_same_and_illegal();
        t_busy();
        t_walk();
        t_late_mode_and_corrupt();
        t_fatal();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule